// File: doc/BRIEF.md
# Power-Down Sequencer with Wakeup Gating

This block decides when a small 4-bit controller core may stop its main clock, and when it must start it again. It watches the instruction stream that the core's decoder has already classified. One instruction arms the sequence and two others request one of two sleep variants. The core's interrupt-enable level, the selected clock source, a set of wakeup enables with their matching conditions, and a timer interrupt flag decide whether a request is honoured. A request is also turned into an immediate return when something is already waiting to wake the core.

When a request is accepted and nothing is pending, the block holds a clock-stop request until an enabled wakeup condition appears. It then releases the clock and gives one cycle in which it pulses a wakeup strobe and a watchdog re-arm strobe. It also records which sleep variant was used. It raises a flag that warns software that the scratch registers (a 2-bit, two 4-bit, a 3-bit and an 8-bit register) no longer hold valid data. The variant record and the flag each stay set until software acknowledges them.

Top module: `pdn_ctrl`

## Requirements
- R1: While reset (`rst`, synchronous, active high) is sampled high, the next cycle shows `clk_stop`, `wake_pulse`, `wdt_rearm` and `regs_invalid` at 0 and `pd_status` at 2'b00, and any recorded arm is discarded.
- R2: An instruction executes in a cycle where `ins_valid` is 1. `ins_op` codes are: 0 for any other instruction, 1 for arm, 2 for sleep request A and 3 for sleep request B. A request is accepted only when the last executed instruction before it was an arm. Cycles with `ins_valid` at 0 do not break the pairing.
- R3: Any executed instruction other than arm clears the recorded arm, and so does reset. An arm issued while asleep or waking is not recorded.
- R4: An arm that executes while `irq_en` is 1 is not recorded.
- R5: While `ext_clk_sel` is 1, no request is accepted.
- R6: An accepted request with no wake condition present raises `clk_stop` in the following cycle. `clk_stop` stays at 1 for as long as no wake condition is present.
- R7: A wake condition is present when the timer flag is 1, or when any of these pairs both read 1: a bit of `p0_wake_lvl` and the same bit of `wk_en_p0`; a bit of `p1_wake_lvl` and the same bit of `wk_en_p1`; `pin0_wake_lvl` and `wk_en_pin[0]`; `pin1_wake_lvl` and `wk_en_pin[2]`. Bits 1 and 3 of `wk_en_pin` have no effect.
- R8: If a wake condition (which includes `tmr_irq_flag`) is present in the cycle a request is accepted, `clk_stop` never rises and the wakeup cycle follows at once.
- R9: A wake condition present while asleep drops `clk_stop` in the next cycle.
- R10: `wake_pulse` and `wdt_rearm` are both 1 for exactly the one cycle after `clk_stop` falls, or the one cycle after an aborted request, and are 0 at all other times.
- R11: An accepted request sets `pd_status` to 2'b01 (request A) or 2'b10 (request B). The value holds until `status_clr` is sampled high while running with no request accepted in the same cycle.
- R12: `regs_invalid` rises together with `wake_pulse`. It stays at 1 until `regs_restored` is sampled high, except in a cycle that starts a new wakeup.
- R13: Reset while asleep drops `clk_stop` without producing `wake_pulse` or `wdt_rearm`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | An instruction executes this cycle |
| ins_op | input | 2 | Instruction class: 0 other, 1 arm, 2 request A, 3 request B |
| irq_en | input | 1 | Interrupt master enable level of the core |
| ext_clk_sel | input | 1 | Main clock comes from an external clock input |
| wk_en_p0 | input | P0_W | Per-bit wakeup enables, port group 0 |
| wk_en_p1 | input | P1_W | Per-bit wakeup enables, port group 1 |
| wk_en_pin | input | 4 | Pin wakeup enables; bit 0 for pin 0, bit 2 for pin 1 |
| p0_wake_lvl | input | P0_W | Wake condition met, per bit of port group 0 |
| p1_wake_lvl | input | P1_W | Wake condition met, per bit of port group 1 |
| pin0_wake_lvl | input | 1 | Wake condition met on interrupt pin 0 |
| pin1_wake_lvl | input | 1 | Wake condition met on interrupt pin 1 |
| tmr_irq_flag | input | 1 | Timer interrupt request flag |
| status_clr | input | 1 | Software clears the sleep-variant record |
| regs_restored | input | 1 | Software has rewritten the scratch registers |
| clk_stop | output | 1 | Request to stop the main clock |
| pd_status | output | 2 | Sleep variant last entered: 00 none, 01 A, 10 B |
| wake_pulse | output | 1 | One-cycle wakeup strobe |
| wdt_rearm | output | 1 | One-cycle watchdog re-enable strobe |
| regs_invalid | output | 1 | Scratch registers hold undefined data |

## Verification
The checker watches, on every cycle, that the clock stop holds while no wake condition is present, that each release of the clock is followed by the paired one-cycle strobes, that the invalid flag accompanies every strobe, that the variant record stays put while asleep, and that an external clock source never lets the clock stop. The rules that decide whether a request counts cannot be seen from any single cycle: arm-then-request pairing, an intervening instruction, an arm issued with interrupts on, a stale arm across reset, and the per-bit enable masking. The bench's scenarios show these, with a behavioural model compared on every clock.

// File: rtl/pdn_pkg.sv
package pdn_pkg;

    typedef enum logic [1:0] {
        OP_OTHER = 2'd0,
        OP_ARM   = 2'd1,
        OP_REQ_A = 2'd2,
        OP_REQ_B = 2'd3
    } pdn_op_e;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_WAKE  = 2'd2
    } pdn_state_e;

    typedef enum logic [1:0] {
        KIND_NONE = 2'b00,
        KIND_A    = 2'b01,
        KIND_B    = 2'b10
    } pdn_kind_e;

    typedef struct packed {
        logic    valid;
        pdn_op_e op;
    } pdn_instr_t;

    localparam int PIN_EN_W = 4;
    localparam int PIN0_BIT = 0;
    localparam int PIN1_BIT = 2;

    function automatic logic is_request(input pdn_op_e op);
        return (op == OP_REQ_A) || (op == OP_REQ_B);
    endfunction

    function automatic pdn_kind_e kind_of(input pdn_op_e op);
        return (op == OP_REQ_B) ? KIND_B : KIND_A;
    endfunction

endpackage

// File: rtl/pdn_arm_track.sv
module pdn_arm_track
    import pdn_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pdn_instr_t ins,
    input  logic       irq_en,
    input  logic       running,
    output logic       armed
);
    logic armed_q;
    logic armed_d;

    always_comb begin
        armed_d = armed_q;
        if (!running) begin
            armed_d = 1'b0;
        end else if (ins.valid) begin
            armed_d = (ins.op == OP_ARM) && !irq_en;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) armed_q <= 1'b0;
        else     armed_q <= armed_d;
    end

    assign armed = armed_q;
endmodule

// File: rtl/pdn_wake_detect.sv
module pdn_wake_detect
    import pdn_pkg::*;
#(
    parameter int P0_W = 4,
    parameter int P1_W = 4
)(
    input  logic [P0_W-1:0]     en_p0,
    input  logic [P1_W-1:0]     en_p1,
    input  logic [PIN_EN_W-1:0] en_pin,
    input  logic [P0_W-1:0]     lvl_p0,
    input  logic [P1_W-1:0]     lvl_p1,
    input  logic                lvl_pin0,
    input  logic                lvl_pin1,
    input  logic                tmr_flag,
    output logic                wake_any
);
    localparam int N_SRC = P0_W + P1_W + 3;

    logic [P0_W-1:0]  hit_p0;
    logic [P1_W-1:0]  hit_p1;
    logic [N_SRC-1:0] hits;
    logic             unused_pin_bits;

    for (genvar i = 0; i < P0_W; i++) begin : g_p0
        assign hit_p0[i] = en_p0[i] & lvl_p0[i];
    end

    for (genvar j = 0; j < P1_W; j++) begin : g_p1
        assign hit_p1[j] = en_p1[j] & lvl_p1[j];
    end

    assign hits = {hit_p1, hit_p0,
                   en_pin[PIN1_BIT] & lvl_pin1,
                   en_pin[PIN0_BIT] & lvl_pin0,
                   tmr_flag};

    assign wake_any = |hits;

    assign unused_pin_bits = en_pin[1] ^ en_pin[3];
endmodule

// File: rtl/pdn_seq.sv
module pdn_seq
    import pdn_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pdn_instr_t ins,
    input  logic       armed,
    input  logic       wake_any,
    input  logic       ext_clk_sel,
    input  logic       status_clr,
    input  logic       regs_restored,
    output pdn_state_e state,
    output pdn_kind_e  kind,
    output logic       regs_invalid
);
    pdn_state_e state_q, state_d;
    pdn_kind_e  kind_q, kind_d;
    logic       inval_q, inval_d;
    logic       accept;
    logic       enter_wake;

    assign accept = (state_q == ST_RUN) && ins.valid && is_request(ins.op)
                    && armed && !ext_clk_sel;

    always_comb begin
        state_d    = state_q;
        enter_wake = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (accept) begin
                    if (wake_any) begin
                        state_d    = ST_WAKE;
                        enter_wake = 1'b1;
                    end else begin
                        state_d = ST_SLEEP;
                    end
                end
            end
            ST_SLEEP: begin
                if (wake_any) begin
                    state_d    = ST_WAKE;
                    enter_wake = 1'b1;
                end
            end
            ST_WAKE: state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        kind_d = kind_q;
        if (accept)                                   kind_d = kind_of(ins.op);
        else if (status_clr && state_q == ST_RUN)     kind_d = KIND_NONE;
    end

    always_comb begin
        inval_d = inval_q;
        if (enter_wake)         inval_d = 1'b1;
        else if (regs_restored) inval_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            kind_q  <= KIND_NONE;
            inval_q <= 1'b0;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
            inval_q <= inval_d;
        end
    end

    assign state        = state_q;
    assign kind         = kind_q;
    assign regs_invalid = inval_q;
endmodule

// File: rtl/pdn_ctrl.sv
module pdn_ctrl
    import pdn_pkg::*;
#(
    parameter int P0_W = 4,
    parameter int P1_W = 4
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                ins_valid,
    input  logic [1:0]          ins_op,
    input  logic                irq_en,
    input  logic                ext_clk_sel,
    input  logic [P0_W-1:0]     wk_en_p0,
    input  logic [P1_W-1:0]     wk_en_p1,
    input  logic [PIN_EN_W-1:0] wk_en_pin,
    input  logic [P0_W-1:0]     p0_wake_lvl,
    input  logic [P1_W-1:0]     p1_wake_lvl,
    input  logic                pin0_wake_lvl,
    input  logic                pin1_wake_lvl,
    input  logic                tmr_irq_flag,
    input  logic                status_clr,
    input  logic                regs_restored,
    output logic                clk_stop,
    output logic [1:0]          pd_status,
    output logic                wake_pulse,
    output logic                wdt_rearm,
    output logic                regs_invalid
);
    pdn_instr_t ins;
    pdn_state_e state;
    pdn_kind_e  kind;
    logic       armed;
    logic       wake_any;

    assign ins.valid = ins_valid;
    assign ins.op    = pdn_op_e'(ins_op);

    pdn_arm_track u_arm (
        .clk     (clk),
        .rst     (rst),
        .ins     (ins),
        .irq_en  (irq_en),
        .running (state == ST_RUN),
        .armed   (armed)
    );

    pdn_wake_detect #(.P0_W(P0_W), .P1_W(P1_W)) u_wake (
        .en_p0    (wk_en_p0),
        .en_p1    (wk_en_p1),
        .en_pin   (wk_en_pin),
        .lvl_p0   (p0_wake_lvl),
        .lvl_p1   (p1_wake_lvl),
        .lvl_pin0 (pin0_wake_lvl),
        .lvl_pin1 (pin1_wake_lvl),
        .tmr_flag (tmr_irq_flag),
        .wake_any (wake_any)
    );

    pdn_seq u_seq (
        .clk           (clk),
        .rst           (rst),
        .ins           (ins),
        .armed         (armed),
        .wake_any      (wake_any),
        .ext_clk_sel   (ext_clk_sel),
        .status_clr    (status_clr),
        .regs_restored (regs_restored),
        .state         (state),
        .kind          (kind),
        .regs_invalid  (regs_invalid)
    );

    assign clk_stop   = (state == ST_SLEEP);
    assign wake_pulse = (state == ST_WAKE);
    assign wdt_rearm  = (state == ST_WAKE);
    assign pd_status  = kind;
endmodule

// File: rtl/pdn_ctrl_chk.sv
module pdn_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       clk_stop,
    input logic       wake_pulse,
    input logic       wdt_rearm,
    input logic [1:0] pd_status,
    input logic       regs_invalid,
    input logic       ext_clk_sel,
    input logic       wake_any
);
    assert_stop_holds_R6: assert property (@(posedge clk) disable iff (rst)
        clk_stop && !wake_any |=> clk_stop);

    assert_wake_drops_stop_R9: assert property (@(posedge clk) disable iff (rst)
        clk_stop && wake_any |=> !clk_stop && wake_pulse);

    assert_fall_gives_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(clk_stop) && !$past(rst) |-> wake_pulse && wdt_rearm);

    assert_pulse_single_R10: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |=> !wake_pulse && !wdt_rearm);

    assert_pulse_flags_regs_R12: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> regs_invalid);

    assert_ext_clk_no_stop_R5: assert property (@(posedge clk) disable iff (rst)
        ext_clk_sel && !clk_stop |=> !clk_stop);

    assert_status_frozen_R11: assert property (@(posedge clk) disable iff (rst)
        clk_stop |=> $stable(pd_status));

    assert_status_code_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pd_status));
endmodule

bind pdn_ctrl pdn_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .clk_stop     (clk_stop),
    .wake_pulse   (wake_pulse),
    .wdt_rearm    (wdt_rearm),
    .pd_status    (pd_status),
    .regs_invalid (regs_invalid),
    .ext_clk_sel  (ext_clk_sel),
    .wake_any     (wake_any)
);

// File: tb/pdn_ctrl_bench.sv
module pdn_ctrl_bench;
    localparam int W0 = 4;
    localparam int W1 = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ins_valid = 1'b0;
    logic [1:0] ins_op = 2'd0;
    logic irq_en = 1'b0;
    logic ext_clk_sel = 1'b0;
    logic [W0-1:0] wk_en_p0 = '0;
    logic [W1-1:0] wk_en_p1 = '0;
    logic [3:0] wk_en_pin = '0;
    logic [W0-1:0] p0_wake_lvl = '0;
    logic [W1-1:0] p1_wake_lvl = '0;
    logic pin0_wake_lvl = 1'b0;
    logic pin1_wake_lvl = 1'b0;
    logic tmr_irq_flag = 1'b0;
    logic status_clr = 1'b0;
    logic regs_restored = 1'b0;
    logic clk_stop, wake_pulse, wdt_rearm, regs_invalid;
    logic [1:0] pd_status;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    pdn_ctrl #(.P0_W(W0), .P1_W(W1)) u_pdn_ctrl (
        .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_op(ins_op),
        .irq_en(irq_en), .ext_clk_sel(ext_clk_sel),
        .wk_en_p0(wk_en_p0), .wk_en_p1(wk_en_p1), .wk_en_pin(wk_en_pin),
        .p0_wake_lvl(p0_wake_lvl), .p1_wake_lvl(p1_wake_lvl),
        .pin0_wake_lvl(pin0_wake_lvl), .pin1_wake_lvl(pin1_wake_lvl),
        .tmr_irq_flag(tmr_irq_flag), .status_clr(status_clr),
        .regs_restored(regs_restored), .clk_stop(clk_stop),
        .pd_status(pd_status), .wake_pulse(wake_pulse),
        .wdt_rearm(wdt_rearm), .regs_invalid(regs_invalid)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: mode 0 running, 1 asleep, 2 waking
    int m_mode = 0;
    bit m_armed = 0;
    int m_stat = 0;
    bit m_inval = 0;

    always @(posedge clk) begin
        bit wk, acc, to_wake;
        wk = tmr_irq_flag || ((wk_en_p0 & p0_wake_lvl) != 0) || ((wk_en_p1 & p1_wake_lvl) != 0)
             || (wk_en_pin[0] && pin0_wake_lvl) || (wk_en_pin[2] && pin1_wake_lvl);
        acc = 0;
        to_wake = 0;
        if (rst) begin
            m_mode = 0; m_armed = 0; m_stat = 0; m_inval = 0;
        end else begin
            if (m_mode == 0) begin
                if (ins_valid) begin
                    if ((ins_op == 2 || ins_op == 3) && m_armed && !ext_clk_sel) acc = 1;
                    m_armed = (ins_op == 1) && !irq_en;
                end
                if (acc) begin
                    m_armed = 0;
                    m_stat = (ins_op == 2) ? 1 : 2;
                    if (wk) begin m_mode = 2; to_wake = 1; end
                    else m_mode = 1;
                end else if (status_clr) m_stat = 0;
            end else if (m_mode == 1) begin
                m_armed = 0;
                if (wk) begin m_mode = 2; to_wake = 1; end
            end else begin
                m_armed = 0;
                m_mode = 0;
            end
            if (to_wake) m_inval = 1;
            else if (regs_restored) m_inval = 0;
        end
    end

    always @(negedge clk) begin
        chk("R6 clk_stop model", clk_stop, m_mode == 1);
        chk("R10 wake_pulse model", wake_pulse, m_mode == 2);
        chk("R10 wdt_rearm model", wdt_rearm, m_mode == 2);
        chk("R11 pd_status model", pd_status, m_stat);
        chk("R12 regs_invalid model", regs_invalid, m_inval);
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            total++;
            bad++;
            $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic instr(input int op);
        ins_valid = 1'b1;
        ins_op = op[1:0];
        @(negedge clk);
        ins_valid = 1'b0;
        ins_op = 2'd0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ack();
        status_clr = 1'b1;
        regs_restored = 1'b1;
        @(negedge clk);
        status_clr = 1'b0;
        regs_restored = 1'b0;
    endtask

    initial begin
        idle(3);
        chk("R1 clk_stop", clk_stop, 0);
        chk("R1 status", pd_status, 0);
        chk("R1 invalid", regs_invalid, 0);
        chk("R1 wake", wake_pulse, 0);
        rst = 1'b0;
        idle(1);

        instr(2);
        chk("R2 lone request", clk_stop, 0);

        instr(1); instr(0); instr(2);
        chk("R3 other between", clk_stop, 0);

        irq_en = 1'b1; instr(1); irq_en = 1'b0; instr(2);
        chk("R4 arm with irq on", clk_stop, 0);

        ext_clk_sel = 1'b1; instr(1); instr(2);
        chk("R5 external clock", clk_stop, 0);
        ext_clk_sel = 1'b0;

        instr(1); idle(2); instr(2);
        chk("R2 arm idle request", clk_stop, 1);
        chk("R6 stop raised", clk_stop, 1);
        chk("R11 variant A", pd_status, 1);
        p0_wake_lvl = 4'hF; wk_en_pin = 4'b1011; pin1_wake_lvl = 1'b1;
        instr(1);
        idle(3);
        chk("R7 disabled sources ignored", clk_stop, 1);
        wk_en_pin = 4'b0100;
        idle(1);
        chk("R9 stop dropped", clk_stop, 0);
        chk("R10 wake pulse", wake_pulse, 1);
        chk("R10 wdt pulse", wdt_rearm, 1);
        chk("R12 invalid set", regs_invalid, 1);
        pin1_wake_lvl = 1'b0; p0_wake_lvl = '0; wk_en_pin = '0;
        idle(1);
        chk("R10 wake one cycle", wake_pulse, 0);
        chk("R10 wdt one cycle", wdt_rearm, 0);
        chk("R11 status held", pd_status, 1);
        chk("R12 invalid held", regs_invalid, 1);
        instr(2);
        chk("R3 arm during sleep not kept", clk_stop, 0);
        status_clr = 1'b1; idle(1); status_clr = 1'b0;
        chk("R11 status cleared", pd_status, 0);
        regs_restored = 1'b1; idle(1); regs_restored = 1'b0;
        chk("R12 invalid cleared", regs_invalid, 0);

        tmr_irq_flag = 1'b1; instr(1); instr(3);
        chk("R8 timer abort stop", clk_stop, 0);
        chk("R8 timer abort wake", wake_pulse, 1);
        chk("R11 variant B", pd_status, 2);
        tmr_irq_flag = 1'b0;
        idle(1);
        ack();

        wk_en_p1 = 4'b0010; p1_wake_lvl = 4'b0010;
        instr(1); instr(2);
        chk("R8 port1 pending abort", wake_pulse, 1);
        chk("R7 port1 enabled bit", clk_stop, 0);
        p1_wake_lvl = '0; wk_en_p1 = '0;
        idle(1); ack();

        wk_en_p0 = 4'b1000; p0_wake_lvl = 4'b0111;
        instr(1); instr(3);
        chk("R7 port0 masked bits", clk_stop, 1);
        p0_wake_lvl = 4'b1000; idle(1);
        chk("R7 port0 enabled bit wakes", wake_pulse, 1);
        p0_wake_lvl = '0; wk_en_p0 = '0;
        idle(1); ack();

        wk_en_pin = 4'b0001;
        instr(1); instr(2);
        chk("R6 asleep for pin0", clk_stop, 1);
        pin0_wake_lvl = 1'b1; idle(1);
        chk("R7 pin0 wakes", wake_pulse, 1);
        pin0_wake_lvl = 1'b0; wk_en_pin = '0;
        idle(1); ack();

        instr(1); instr(2);
        chk("R6 asleep before reset", clk_stop, 1);
        rst = 1'b1; idle(1);
        chk("R13 reset drops stop", clk_stop, 0);
        chk("R13 no wake pulse", wake_pulse, 0);
        chk("R13 no wdt pulse", wdt_rearm, 0);
        rst = 1'b0; idle(1);
        chk("R13 still no pulse", wake_pulse, 0);

        instr(1);
        rst = 1'b1; idle(1); rst = 1'b0;
        instr(2);
        chk("R3 reset clears arm", clk_stop, 0);
        chk("R1 status after reset", pd_status, 0);

        idle(2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule